// File: doc/BRIEF.md
# Directional Indirect Pixel Write Stepper

This block holds a byte-linear destination address and turns each 32-bit data word written over a small register bus into a burst of single-pixel writes on a valid/ready pixel port. Every pixel occupies four bytes, and a line is 2048 pixels (8192 bytes). A configuration register selects one of three formats. In colour expansion, each data bit picks the foreground or background colour. In 8-bit direct mode, each data byte is one pixel. In 24-bit direct mode, one pixel takes the low 24 bits. A left-aligned slot mask limits which pixel slots of a word take effect.

Eight data registers accept the same word and differ only in how the destination moves once that word's pixel writes have all been accepted. The moves are one word-width right or left, one line down or up, or a diagonal. A glyph or sprite can therefore be streamed line by line without rewriting the address. While a word is being emitted the block reports busy and ignores every register write.

Register select map (`wrSel`): 0 destination, 1 slot mask, 2 foreground, 3 background, 4 control, 5 to 7 no effect, 8 to 15 data.

Top module: `indirect_pixel_stepper`

## Requirements
- R1: After reset, busy and pixValid are low. The destination is 0, the mask is all ones, the foreground and background are 0, and the mode is opaque colour expansion.
- R2: Slot k of a word is written at destination + 4*k (modulo 2^ADDR_W). It is gated by mask bit 31-k, and slots are issued in increasing k.
- R3: In expansion mode (control bits [1:0] = 0), a word has 32 slots. Slot k writes the foreground colour if data bit 31-k is set, and the background colour if it is clear.
- R4: With control bit 2 set in expansion mode, slots whose data bit is clear issue no pixel write.
- R5: In 8-bit mode (control bits [1:0] = 1), a word has 4 slots. Slot k carries data bits [31-8k:24-8k], zero-extended to 32 bits.
- R6: In 24-bit mode (control bits [1:0] = 2 or 3), a word has 1 slot carrying data bits [23:0], zero-extended.
- R7: A slot whose mask bit is clear issues no pixel write.
- R8: The data register at select 8 to 15 steps the destination by, respectively: +X, +Y, -Y, -X, +X+Y, -X+Y, +X-Y and -X-Y.
- R9: An X step moves by (slots per word)*4 bytes, and a Y step moves by 8192 bytes.
- R10: Busy is high from the cycle after a data write until the word's last slot is accepted. A pixel write holds until pixReady, and the step applies only after the last slot.
- R11: Any register write made while busy is high has no effect.
- R12: The destination wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 4 | Register select |
| wrData | input | 32 | Register write data |
| busy | output | 1 | Word being emitted, writes ignored |
| pixValid | output | 1 | Pixel write request |
| pixReady | input | 1 | Pixel write accepted |
| pixAddr | output | ADDR_W | Pixel byte address |
| pixColor | output | 32 | Pixel value |

## Verification
The bench builds the block with its default parameters: a 24-bit address, 2048-pixel lines and 4-byte pixels. A destination near 2^24 is therefore a few writes away, which makes the modulo wrap reachable with a directed +X step. The destination is not readable, so each step is checked through the addresses of the next word's pixel writes. A back-pressured ready mixes stalled and accepted slots across all three formats and all eight step registers.

// File: rtl/pix_step_pkg.sv
package pix_step_pkg;
  typedef enum logic [1:0] {
    MODE_EXPAND = 2'd0,
    MODE_BYTE   = 2'd1,
    MODE_WIDE   = 2'd2,
    MODE_WIDE2  = 2'd3
  } pixModeT;

  typedef struct packed {
    logic acceptCfg;
    logic acceptData;
    logic nextSlot;
    logic finish;
  } stepStbT;

  localparam logic [3:0] SEL_DEST = 4'd0;
  localparam logic [3:0] SEL_MASK = 4'd1;
  localparam logic [3:0] SEL_FG   = 4'd2;
  localparam logic [3:0] SEL_BG   = 4'd3;
  localparam logic [3:0] SEL_CTRL = 4'd4;
endpackage

// File: rtl/pix_step_ctrl.sv
module pix_step_ctrl
  import pix_step_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [3:0]  wrSel,
  input  logic        slotActive,
  input  logic        slotLast,
  input  logic        pixReady,
  output stepStbT     stb,
  output logic        busy,
  output logic        pixValid
);
  typedef enum logic {ST_IDLE, ST_RUN} stateT;
  stateT state, nextState;

  always_comb begin
    stb       = '0;
    pixValid  = 1'b0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (wrEn) begin
          if (wrSel[3]) begin
            stb.acceptData = 1'b1;
            nextState      = ST_RUN;
          end else begin
            stb.acceptCfg = 1'b1;
          end
        end
      end
      default: begin
        pixValid = slotActive;
        if (!slotActive || pixReady) begin
          if (slotLast) begin
            stb.finish = 1'b1;
            nextState  = ST_IDLE;
          end else begin
            stb.nextSlot = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign busy = (state == ST_RUN);

  // R10
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixValid && !pixReady |=> pixValid);
  // R10
  busy_after_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.acceptData |=> busy);
  // R1
  valid_needs_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> busy);
  // R11
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.acceptCfg, stb.acceptData, stb.nextSlot, stb.finish}));
endmodule

// File: rtl/pix_step_dp.sv
module pix_step_dp
  import pix_step_pkg::*;
#(
  parameter int ADDR_W          = 24,
  parameter int LINE_PIXELS     = 2048,
  parameter int BYTES_PER_PIXEL = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  stepStbT           stb,
  input  logic [3:0]        wrSel,
  input  logic [31:0]       wrData,
  output logic              slotActive,
  output logic              slotLast,
  output logic [ADDR_W-1:0] pixAddr,
  output logic [31:0]       pixColor
);
  localparam int LINE_BYTES = LINE_PIXELS * BYTES_PER_PIXEL;
  localparam logic [ADDR_W-1:0] V_STEP = ADDR_W'(LINE_BYTES);

  logic [ADDR_W-1:0] destAddr;
  logic [31:0]       maskReg, fgReg, bgReg, wordReg;
  pixModeT           modeReg;
  logic              bgTransp;
  logic [2:0]        stepCode;
  logic [4:0]        slotIdx;

  logic [5:0]        pixPerWord;
  logic [4:0]        bitPos;
  logic [31:0]       byteShifted;
  logic [ADDR_W-1:0] hStep, xOff, yOff, nextDest;
  logic              xPos, xNeg, yPos, yNeg;

  always_comb begin
    case (modeReg)
      MODE_EXPAND: pixPerWord = 6'd32;
      MODE_BYTE:   pixPerWord = 6'd4;
      default:     pixPerWord = 6'd1;
    endcase
  end

  assign bitPos      = 5'd31 - slotIdx;
  assign byteShifted = wordReg << {slotIdx[1:0], 3'b000};
  assign slotLast    = ({1'b0, slotIdx} == pixPerWord - 6'd1);

  always_comb begin
    slotActive = maskReg[bitPos];
    if (modeReg == MODE_EXPAND && bgTransp && !wordReg[bitPos])
      slotActive = 1'b0;
  end

  always_comb begin
    case (modeReg)
      MODE_EXPAND: pixColor = wordReg[bitPos] ? fgReg : bgReg;
      MODE_BYTE:   pixColor = {24'd0, byteShifted[31:24]};
      default:     pixColor = {8'd0, wordReg[23:0]};
    endcase
  end

  assign pixAddr = destAddr + ADDR_W'(32'(slotIdx) * BYTES_PER_PIXEL);

  // step direction per data register: +X,+Y,-Y,-X,+X+Y,-X+Y,+X-Y,-X-Y
  always_comb begin
    xPos = 1'b0; xNeg = 1'b0; yPos = 1'b0; yNeg = 1'b0;
    case (stepCode)
      3'd0: xPos = 1'b1;
      3'd1: yPos = 1'b1;
      3'd2: yNeg = 1'b1;
      3'd3: xNeg = 1'b1;
      3'd4: begin xPos = 1'b1; yPos = 1'b1; end
      3'd5: begin xNeg = 1'b1; yPos = 1'b1; end
      3'd6: begin xPos = 1'b1; yNeg = 1'b1; end
      default: begin xNeg = 1'b1; yNeg = 1'b1; end
    endcase
  end

  assign hStep    = ADDR_W'(32'(pixPerWord) * BYTES_PER_PIXEL);
  assign xOff     = xPos ? hStep : (xNeg ? (~hStep + 1'b1) : '0);
  assign yOff     = yPos ? V_STEP : (yNeg ? (~V_STEP + 1'b1) : '0);
  assign nextDest = destAddr + xOff + yOff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      destAddr <= '0;
      maskReg  <= '1;
      fgReg    <= '0;
      bgReg    <= '0;
      modeReg  <= MODE_EXPAND;
      bgTransp <= 1'b0;
      wordReg  <= '0;
      stepCode <= '0;
      slotIdx  <= '0;
    end else begin
      if (stb.acceptCfg) begin
        case (wrSel)
          SEL_DEST: destAddr <= wrData[ADDR_W-1:0];
          SEL_MASK: maskReg  <= wrData;
          SEL_FG:   fgReg    <= wrData;
          SEL_BG:   bgReg    <= wrData;
          SEL_CTRL: begin
            modeReg  <= pixModeT'(wrData[1:0]);
            bgTransp <= wrData[2];
          end
          default: ;
        endcase
      end
      if (stb.acceptData) begin
        wordReg  <= wrData;
        stepCode <= wrSel[2:0];
        slotIdx  <= '0;
      end
      if (stb.nextSlot) slotIdx <= slotIdx + 5'd1;
      if (stb.finish)   destAddr <= nextDest;
    end
  end

  // R10
  slot_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.nextSlot |-> !slotLast);
  // R11
  dest_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.finish && !(stb.acceptCfg && wrSel == SEL_DEST) |=> $stable(destAddr));
endmodule

// File: rtl/indirect_pixel_stepper.sv
module indirect_pixel_stepper
  import pix_step_pkg::*;
#(
  parameter int ADDR_W          = 24,
  parameter int LINE_PIXELS     = 2048,
  parameter int BYTES_PER_PIXEL = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [3:0]        wrSel,
  input  logic [31:0]       wrData,
  output logic              busy,
  output logic              pixValid,
  input  logic              pixReady,
  output logic [ADDR_W-1:0] pixAddr,
  output logic [31:0]       pixColor
);
  stepStbT stb;
  logic    slotActive, slotLast;

  pix_step_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
    .slotActive(slotActive), .slotLast(slotLast), .pixReady(pixReady),
    .stb(stb), .busy(busy), .pixValid(pixValid)
  );

  pix_step_dp #(
    .ADDR_W(ADDR_W), .LINE_PIXELS(LINE_PIXELS), .BYTES_PER_PIXEL(BYTES_PER_PIXEL)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrSel(wrSel), .wrData(wrData),
    .slotActive(slotActive), .slotLast(slotLast),
    .pixAddr(pixAddr), .pixColor(pixColor)
  );
endmodule

// File: tb/indirect_pixel_stepper_test.sv
module indirect_pixel_stepper_test;
  localparam int AW = 24;
  localparam logic [31:0] AMASK = (32'd1 << AW) - 1;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, pixReady = 1'b0;
  logic [3:0] wrSel = '0;
  logic [31:0] wrData = '0;
  logic busy, pixValid;
  logic [AW-1:0] pixAddr;
  logic [31:0] pixColor;

  indirect_pixel_stepper uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .busy(busy), .pixValid(pixValid), .pixReady(pixReady),
    .pixAddr(pixAddr), .pixColor(pixColor)
  );

  always #5 clk = ~clk;

  int testCount = 0, failCount = 0, cycles = 0;
  logic [31:0] mDest, mMask, mFg, mBg;
  logic [1:0]  mMode;
  logic        mTransp;
  logic [31:0] expA[64], expD[64], gotA[64], gotD[64];
  int expN, gotN;
  int readyPct = 70;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failCount++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", testCount + 1, failCount);
      $finish;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg(logic [3:0] sel, logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk); wrEn = 1'b0;
    case (sel)
      4'd0: mDest = d & AMASK;
      4'd1: mMask = d;
      4'd2: mFg = d;
      4'd3: mBg = d;
      4'd4: begin mMode = d[1:0]; mTransp = d[2]; end
      default: ;
    endcase
  endtask

  function automatic int ppw(logic [1:0] m);
    return (m == 2'd0) ? 32 : (m == 2'd1) ? 4 : 1;
  endfunction

  // builds expected pixel list then applies step (R2..R9, R12)
  task automatic model(logic [2:0] step, logic [31:0] w);
    int n = ppw(mMode);
    int dx, dy;
    logic [31:0] sh;
    expN = 0;
    for (int k = 0; k < n; k++) begin
      if (mMask[31-k] && !(mMode == 2'd0 && mTransp && !w[31-k])) begin
        expA[expN] = (mDest + 32'(4*k)) & AMASK;
        sh = w << (8*k);
        expD[expN] = (mMode == 2'd0) ? (w[31-k] ? mFg : mBg) :
                     (mMode == 2'd1) ? {24'd0, sh[31:24]} : {8'd0, w[23:0]};
        expN++;
      end
    end
    dx = (step == 0 || step == 4 || step == 6) ? 1 :
         (step == 3 || step == 5 || step == 7) ? -1 : 0;
    dy = (step == 1 || step == 4 || step == 5) ? 1 :
         (step == 2 || step == 6 || step == 7) ? -1 : 0;
    mDest = (mDest + 32'(dx * n * 4) + 32'(dy * 8192)) & AMASK;
  endtask

  task automatic sendWord(string tag, logic [2:0] step, logic [31:0] w, bit intrude);
    int first = 1;
    model(step, w);
    gotN = 0;
    @(negedge clk); wrEn = 1'b1; wrSel = {1'b1, step}; wrData = w;
    forever begin
      @(negedge clk);
      if (first == 1) begin
        check({tag, " R10 busy raised"}, {31'd0, busy}, 32'd1);
        if (intrude) begin
          wrEn = 1'b1; wrSel = 4'd0; wrData = 32'h00ABCDE0; // R11 dest write while busy
        end else wrEn = 1'b0;
        first = 0;
      end else wrEn = 1'b0;
      if (!busy) break;
      pixReady = (($urandom % 100) < readyPct);
      #1;
      if (pixValid && pixReady && gotN < 64) begin
        gotA[gotN] = 32'(pixAddr); gotD[gotN] = pixColor; gotN++;
      end
    end
    wrEn = 1'b0;
    check({tag, " count"}, 32'(gotN), 32'(expN));
    for (int i = 0; i < expN && i < gotN; i++) begin
      if (gotA[i] !== expA[i] || gotD[i] !== expD[i]) begin
        check({tag, " pixel"}, gotA[i] ^ gotD[i], expA[i] ^ expD[i]);
        if (gotA[i] !== expA[i]) $display("  addr actual %h expected %h", gotA[i], expA[i]);
        return;
      end
    end
    testCount++;
  endtask

  initial begin
    void'($urandom(32'd4242));
    mDest = 0; mMask = '1; mFg = 0; mBg = 0; mMode = 0; mTransp = 0;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", {31'd0, busy}, 32'd0);
    check("R1 valid in reset", {31'd0, pixValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", {31'd0, busy}, 32'd0);
    sendWord("R1 defaults", 3'd0, 32'hA5A5_0F0F, 0);

    // R3 expansion opaque, R2 slot order
    cfg(4'd2, 32'h00FF_1234); cfg(4'd3, 32'h0000_5678);
    sendWord("R3 expand", 3'd1, 32'hF00F_8001, 0);
    // R4 transparency
    cfg(4'd4, 32'd4);
    sendWord("R4 transparent", 3'd3, 32'h8421_0000, 0);
    // R7 mask, glyph at (100,150) streamed down with 12-pixel mask
    cfg(4'd0, 32'd1229200); cfg(4'd1, 32'hFFF0_0000); cfg(4'd4, 32'd0);
    for (int r = 0; r < 3; r++) sendWord("R7 R9 glyph", 3'd1, 32'hFFFF_FFFF ^ (32'h1 << (20 + r)), 0);
    // R5 8-bit mode
    cfg(4'd1, 32'hB000_0000); cfg(4'd4, 32'd1);
    sendWord("R5 byte", 3'd0, 32'h1122_3344, 0);
    cfg(4'd1, 32'hF000_0000);
    sendWord("R5 byte full", 3'd4, 32'hDEAD_BEEF, 0);
    // R6 24-bit, all eight steps R8
    cfg(4'd4, 32'd2); cfg(4'd0, 32'h0010_0000);
    for (int s = 0; s < 8; s++) sendWord("R8 step", 3'(s), 32'hCC00_0000 + 32'(s), 0);
    cfg(4'd4, 32'd3);
    sendWord("R6 wide alt", 3'd7, 32'h8765_4321, 0);
    // R12 wrap
    cfg(4'd4, 32'd2); cfg(4'd1, 32'hFFFF_FFFF); cfg(4'd0, 32'h00FF_FFFC);
    sendWord("R12 wrap", 3'd0, 32'h0012_3456, 0);
    sendWord("R12 after wrap", 3'd2, 32'h0065_4321, 0);
    // R11 write during busy ignored (next word exposes destination)
    cfg(4'd4, 32'd0);
    sendWord("R11 intrude", 3'd0, 32'h0F0F_0F0F, 1);
    sendWord("R11 dest kept", 3'd0, 32'hFFFF_0000, 0);
    // register selects 5..7 have no effect
    cfg(4'd5, 32'hFFFF_FFFF);
    sendWord("R11 unused sel", 3'd1, 32'h1234_5678, 0);

    // R10 random traffic with back-pressure
    for (int i = 0; i < 40; i++) begin
      readyPct = 30 + int'($urandom % 70);
      if ($urandom % 3 == 0) cfg(4'd4, $urandom % 8);
      if ($urandom % 3 == 0) cfg(4'd1, $urandom);
      if ($urandom % 4 == 0) cfg(4'd2, $urandom);
      if ($urandom % 4 == 0) cfg(4'd3, $urandom);
      if ($urandom % 5 == 0) cfg(4'd0, $urandom);
      sendWord("R10 random", 3'($urandom % 8), $urandom, ($urandom % 4) == 0);
    end

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule